// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs a page-organised serial flash device over a four-wire link. The four wires are an active-low select, a serial clock, a command/data line toward the device and a data line back from it. The host pulses `start_i` with one of three operations: read a page, write into one of two on-chip SRAM buffers, or program a buffer into a main-memory page. The sequencer builds the command frame for that operation and shifts it out MSB first. It then streams the requested number of data bytes, in or out, one byte per handshake.

The device geometry is 528 bytes per page and per buffer. The byte address advances with every data byte. When it steps past the last byte (527), it returns to 0 and a wrap strobe is raised. A request whose start address lies outside the page, or whose operation code is the reserved one, is refused with an error strobe. The select line is held low for the whole transaction. It is released after the last bit and stays high for at least one system clock before the block is idle again.

Top module: `sflash_seq`

## Requirements
- R1: After reset `cs_n_o`=1, `sck_o`=0, `busy_o`=0, `done_o`=0, `err_o`=0, `rd_valid_o`=0 and `wr_take_o`=0.
- R2: Page read (`op_i`=0) sends 62 bits MSB first: opcode 8'hD2, the 12-bit `page_i`, the 10-bit `byte_i`, then 32 zero bits.
- R3: Buffer write (`op_i`=1) sends 30 bits: opcode 8'h84 (`buf_sel_i`=0) or 8'h87 (`buf_sel_i`=1), 12 zero bits, then the 10-bit `byte_i`. `len_i` data bytes follow, each MSB first.
- R4: Program (`op_i`=2) sends 30 bits: opcode 8'h83 (`buf_sel_i`=0) or 8'h86 (`buf_sel_i`=1), the 12-bit `page_i`, then 10 zero bits. No data follows. `byte_i` and `len_i` are ignored.
- R5: `sck_o` idles low and toggles only while `cs_n_o` is low. `si_o` changes only while `sck_o` is low, so it is stable at every rising edge.
- R6: In a read, `so_i` is sampled during each high phase of `sck_o` and assembled MSB first. After each eighth bit, `rd_valid_o` pulses for one cycle with the byte on `rd_data_o`. Exactly `len_i` bytes are returned.
- R7: In a buffer write, `wr_take_o` pulses once per data byte, and `wr_data_i` is latched in that cycle. Exactly `len_i` pulses occur.
- R8: The data byte address starts at `byte_i` and steps by one per byte. Stepping past 527 returns it to 0 and pulses `wrap_o` in the same cycle as that byte's completion.
- R9: A start with `op_i`=3, or with read/write and `byte_i` of 528 or more, pulses `err_o` one cycle later. It does not assert `cs_n_o`, and `busy_o` stays low.
- R10: `cs_n_o` rises after the last bit and stays high for at least two cycles. `done_o` pulses one cycle after the rise, with `busy_o` low.
- R11: A `start_i` that arrives while `busy_o` is high is ignored.
- R12: A read or buffer write with `len_i`=0 sends only the command frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| op_i | input | 2 | 0 read, 1 buffer write, 2 program, 3 reserved |
| buf_sel_i | input | 1 | 0 first buffer, 1 second buffer |
| page_i | input | 12 | Page address |
| byte_i | input | 10 | Starting byte address |
| len_i | input | 10 | Data byte count |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Transaction finished strobe |
| err_o | output | 1 | Request refused strobe |
| wr_data_i | input | 8 | Write byte from host |
| wr_take_o | output | 1 | Write byte consumed strobe |
| rd_data_o | output | 8 | Read byte to host |
| rd_valid_o | output | 1 | Read byte valid strobe |
| wrap_o | output | 1 | Byte address wrapped strobe |
| cs_n_o | output | 1 | Device select, active low |
| sck_o | output | 1 | Serial clock |
| si_o | output | 1 | Serial data to device |
| so_i | input | 1 | Serial data from device |

## Verification
The stimulus covers all three frame layouts, with both buffer selections and with page and byte values whose bits differ from one another. This exposes a swapped field, a wrong opcode choice or a shift in the wrong direction. Reads and writes are run both away from the page end and straddling byte 527, which separates correct wrapping from overrun or a wrap in the wrong position. Zero-length transfers, a program carrying a large ignored byte address, refused requests and a start issued mid-transaction each check that no stray frame, data byte or completion appears.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_BUFWR = 2'd1,
    OP_PROG  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_GAP
  } st_e;
endpackage

// File: rtl/sflash_frame.sv
module sflash_frame
  import sflash_pkg::*;
#(
  parameter int OPC_W   = 8,
  parameter int PAGE_W  = 12,
  parameter int BYTE_W  = 10,
  parameter int DUMMY_W = 32,
  parameter logic [OPC_W-1:0] OPC_RD  = 8'hD2,
  parameter logic [OPC_W-1:0] OPC_WR1 = 8'h84,
  parameter logic [OPC_W-1:0] OPC_WR2 = 8'h87,
  parameter logic [OPC_W-1:0] OPC_PG1 = 8'h83,
  parameter logic [OPC_W-1:0] OPC_PG2 = 8'h86,
  localparam int FRAME_W = OPC_W + PAGE_W + BYTE_W + DUMMY_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  op_e                op_i,
  input  logic               buf_sel_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);
  localparam int SHORT_W = OPC_W + PAGE_W + BYTE_W;

  always_comb begin
    unique case (op_i)
      OP_BUFWR: begin
        frame_o = {buf_sel_i ? OPC_WR2 : OPC_WR1, {PAGE_W{1'b0}}, byte_i, {DUMMY_W{1'b0}}};
        nbits_o = CNT_W'(SHORT_W);
      end
      OP_PROG: begin
        frame_o = {buf_sel_i ? OPC_PG2 : OPC_PG1, page_i, {BYTE_W{1'b0}}, {DUMMY_W{1'b0}}};
        nbits_o = CNT_W'(SHORT_W);
      end
      default: begin
        frame_o = {OPC_RD, page_i, byte_i, {DUMMY_W{1'b0}}};
        nbits_o = CNT_W'(FRAME_W);
      end
    endcase
  end
endmodule

// File: rtl/sflash_shift.sv
module sflash_shift #(
  parameter int FRAME_W = 62,
  parameter int DATA_W  = 8,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               so_i,
  output logic               sck_o,
  output logic               si_o,
  output logic               seg_done_o,
  output logic [DATA_W-1:0]  rx_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               run_q, ph_q, done_q;
  logic [DATA_W-1:0]  rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        sh_q  <= word_i;
        cnt_q <= nbits_i;
        run_q <= 1'b1;
        ph_q  <= 1'b0;
      end else if (run_q) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          // falling edge: advance output, capture input sampled in high phase
          ph_q  <= 1'b0;
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          rx_q  <= {rx_q[DATA_W-2:0], so_i};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck_o      = ph_q;
  assign si_o       = sh_q[FRAME_W-1];
  assign seg_done_o = done_q;
  assign rx_o       = rx_q;

  a_r5_si_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(si_o));
  a_r5_sck_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> run_q);
endmodule

// File: rtl/sflash_addr.sv
module sflash_addr #(
  parameter int BYTE_W     = 10,
  parameter int PAGE_BYTES = 528
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              step_i,
  output logic              wrap_o
);
  localparam logic [BYTE_W-1:0] LAST = BYTE_W'(PAGE_BYTES - 1);

  logic [BYTE_W-1:0] addr_q;
  logic              wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (load_i) begin
        addr_q <= addr_i;
      end else if (step_i) begin
        if (addr_q == LAST) begin
          addr_q <= '0;
          wrap_q <= 1'b1;
        end else begin
          addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  assign wrap_o = wrap_q;

  a_r8_addr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST);
  a_r8_wrap_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && addr_q == LAST) |=> (wrap_o && addr_q == '0));
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int OPC_W      = 8,
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 10,
  parameter int DUMMY_W    = 32,
  parameter int PAGE_BYTES = 528,
  parameter int LEN_W      = 10,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              buf_sel_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_take_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              wrap_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              si_o,
  input  logic              so_i
);
  localparam int FRAME_W = OPC_W + PAGE_W + BYTE_W + DUMMY_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  st_e               state_q;
  op_e               op_q, op_in;
  logic [LEN_W-1:0]  rem_q;
  logic              cs_n_q, done_q, err_q, rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  logic [FRAME_W-1:0] frame, eng_word;
  logic [CNT_W-1:0]   frame_bits, eng_bits;
  logic               bad, accept, data_go, eng_load, seg_done;
  logic [DATA_W-1:0]  eng_rx;

  assign op_in  = op_e'(op_i);
  assign bad    = (op_in == OP_RSVD) ||
                  (op_in != OP_PROG && byte_i >= BYTE_W'(PAGE_BYTES));
  assign accept = (state_q == ST_IDLE) && start_i && !bad;

  assign data_go = seg_done &&
    ((state_q == ST_CMD  && op_q != OP_PROG && rem_q != '0) ||
     (state_q == ST_DATA && rem_q > LEN_W'(1)));

  assign eng_load = accept || data_go;
  assign eng_word = accept ? frame :
                    {(op_q == OP_BUFWR) ? wr_data_i : {DATA_W{1'b0}}, {(FRAME_W-DATA_W){1'b0}}};
  assign eng_bits = accept ? frame_bits : CNT_W'(DATA_W);

  sflash_frame #(
    .OPC_W(OPC_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .DUMMY_W(DUMMY_W)
  ) u_frame (
    .op_i     (op_in),
    .buf_sel_i(buf_sel_i),
    .page_i   (page_i),
    .byte_i   (byte_i),
    .frame_o  (frame),
    .nbits_o  (frame_bits)
  );

  sflash_shift #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (eng_load),
    .word_i    (eng_word),
    .nbits_i   (eng_bits),
    .so_i      (so_i),
    .sck_o     (sck_o),
    .si_o      (si_o),
    .seg_done_o(seg_done),
    .rx_o      (eng_rx)
  );

  sflash_addr #(.BYTE_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept && op_in != OP_PROG),
    .addr_i(byte_i),
    .step_i(seg_done && state_q == ST_DATA),
    .wrap_o(wrap_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_READ;
      rem_q      <= '0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (bad) begin
            err_q <= 1'b1;
          end else begin
            state_q <= ST_CMD;
            cs_n_q  <= 1'b0;
            op_q    <= op_in;
            rem_q   <= len_i;
          end
        end
        ST_CMD: if (seg_done) begin
          if (op_q == OP_PROG || rem_q == '0) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_GAP;
          end else begin
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (seg_done) begin
          rem_q <= rem_q - 1'b1;
          if (op_q == OP_READ) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= eng_rx;
          end
          if (rem_q == LEN_W'(1)) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign cs_n_o     = cs_n_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign wr_take_o  = data_go && (op_q == OP_BUFWR);

  a_r5_sck_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_n_o);
  a_r10_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |=> cs_n_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cs_n_o));
  a_r9_err_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_n_o && !busy_o));
  a_r6_valid_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (op_q == OP_READ));
  a_r7_take_only_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take_o |-> (op_q == OP_BUFWR && !cs_n_o && !sck_o));
endmodule

// File: tb/sflash_seq_tb.sv
`timescale 1ns/1ps
module sflash_seq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        buf_sel_i = 1'b0;
  logic [11:0] page_i = '0;
  logic [9:0]  byte_i = '0;
  logic [9:0]  len_i = '0;
  logic [7:0]  wr_data_i;
  logic        so_i = 1'b0;
  logic        busy_o, done_o, err_o, wr_take_o, rd_valid_o, wrap_o;
  logic        cs_n_o, sck_o, si_o;
  logic [7:0]  rd_data_o;

  sflash_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .buf_sel_i(buf_sel_i), .page_i(page_i), .byte_i(byte_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .wr_data_i(wr_data_i),
    .wr_take_o(wr_take_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .wrap_o(wrap_o), .cs_n_o(cs_n_o), .sck_o(sck_o), .si_o(si_o), .so_i(so_i)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] rpat(int k);
    return 8'(8'hA5 + k * 8'h1D);
  endfunction
  function automatic logic [7:0] wpat(int k);
    return 8'(8'h3C ^ (k * 7));
  endfunction

  // host-side counters
  int done_cnt = 0, err_cnt = 0, take_cnt = 0, rd_cnt = 0, wrap_cnt = 0, wrap_at = -1;
  logic [7:0] rd_buf [0:255];
  assign wr_data_i = wpat(take_cnt);
  always @(posedge clk_i) begin
    if (done_o) done_cnt <= done_cnt + 1;
    if (err_o) err_cnt <= err_cnt + 1;
    if (wr_take_o) take_cnt <= take_cnt + 1;
    if (rd_valid_o) begin
      rd_buf[rd_cnt[7:0]] <= rd_data_o;
      rd_cnt <= rd_cnt + 1;
    end
    if (wrap_o) begin
      wrap_cnt <= wrap_cnt + 1;
      wrap_at <= rd_cnt;
    end
  end

  // device model
  int nb_total = 0, nb_base = 0;
  logic cap [0:511];
  always @(negedge cs_n_o) nb_base = nb_total;
  always @(posedge sck_o) begin
    cap[(nb_total - nb_base) % 512] = si_o;
    nb_total = nb_total + 1;
  end
  always @(negedge sck_o) begin
    #1;
    if (nb_total - nb_base >= 62) begin
      int d;
      d = nb_total - nb_base - 62;
      so_i = rpat(d / 8)[7 - (d % 8)];
    end
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      report();
    end
  end

  function automatic logic [61:0] exp_frame(int op, int bs, int pg, int by);
    logic [7:0] opc;
    case (op)
      0: return {8'hD2, 12'(pg), 10'(by), 32'h0};
      1: begin opc = bs ? 8'h87 : 8'h84; return {opc, 12'h0, 10'(by), 32'h0}; end
      default: begin opc = bs ? 8'h86 : 8'h83; return {opc, 12'(pg), 10'h0, 32'h0}; end
    endcase
  endfunction

  task automatic pulse_start(int op, int bs, int pg, int by, int ln);
    @(negedge clk_i);
    op_i = 2'(op); buf_sel_i = bs[0]; page_i = 12'(pg); byte_i = 10'(by); len_i = 10'(ln);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(int d0);
    while (done_cnt == d0) @(negedge clk_i);
  endtask

  task automatic run_txn(int op, int bs, int pg, int by, int ln, bit mid_start);
    int d0, t0, r0, w0, cmdb, expb, nb, eff_len, bad_at;
    logic [61:0] got, exp;
    string rq;
    d0 = done_cnt; t0 = take_cnt; r0 = rd_cnt; w0 = wrap_cnt;
    rq = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
    pulse_start(op, bs, pg, by, ln);
    if (mid_start) begin
      // R11: second request while busy
      repeat (3) @(negedge clk_i);
      op_i = 2'd2; page_i = 12'h0F0; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait_done(d0);
    repeat (3) @(negedge clk_i);
    nb = nb_total - nb_base;
    cmdb = (op == 0) ? 62 : 30;
    eff_len = (op == 2) ? 0 : ln;
    expb = cmdb + 8 * eff_len;
    got = '0;
    for (int i = 0; i < cmdb; i++) got[61 - i] = cap[i];
    exp = exp_frame(op, bs, pg, by);
    check(got == exp, rq, "command frame", 64'(got), 64'(exp));
    check(nb == expb, (ln == 0) ? "R12" : "R4", "bit count", 64'(nb), 64'(expb));
    check(done_cnt - d0 == 1, "R10", "done pulses", 64'(done_cnt - d0), 64'd1);
    if (mid_start)
      check(done_cnt - d0 == 1 && nb == expb, "R11", "busy start ignored", 64'(nb), 64'(expb));
    check(rd_cnt - r0 == ((op == 0) ? eff_len : 0), "R6", "read bytes", 64'(rd_cnt - r0),
          64'((op == 0) ? eff_len : 0));
    check(take_cnt - t0 == ((op == 1) ? eff_len : 0), "R7", "write takes", 64'(take_cnt - t0),
          64'((op == 1) ? eff_len : 0));
    if (op == 0 && eff_len > 0) begin
      bad_at = -1;
      for (int k = 0; k < eff_len; k++)
        if (bad_at < 0 && rd_buf[(r0 + k) % 256] != rpat(k)) bad_at = k;
      check(bad_at < 0, "R6", "read data", (bad_at < 0) ? 64'd0 : 64'(rd_buf[(r0 + bad_at) % 256]),
            (bad_at < 0) ? 64'd0 : 64'(rpat(bad_at)));
    end
    if (op == 1 && eff_len > 0) begin
      bad_at = -1;
      for (int k = 0; k < eff_len && bad_at < 0; k++) begin
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[7 - j] = cap[30 + 8 * k + j];
        if (b != wpat(t0 + k)) bad_at = k;
      end
      check(bad_at < 0, "R7", "write data on si", 64'(bad_at), 64'hFFFF_FFFF_FFFF_FFFF);
    end
    if (op != 2) begin
      int ew;
      ew = (eff_len > 0 && by + eff_len > 528) ? 1 : 0;
      check(wrap_cnt - w0 == ew, "R8", "wrap pulses", 64'(wrap_cnt - w0), 64'(ew));
      if (ew == 1 && op == 0)
        check(wrap_at - r0 == 527 - by, "R8", "wrap position", 64'(wrap_at - r0), 64'(527 - by));
    end
  endtask

  // {op[34:33], buf_sel[32], page[31:20], byte[19:10], len[9:0]}
  localparam logic [34:0] VEC [8] = '{
    {2'd0, 1'b0, 12'hA5C, 10'd19,   10'd3},
    {2'd0, 1'b0, 12'h001, 10'd526,  10'd4},
    {2'd1, 1'b0, 12'h777, 10'd496,  10'd2},
    {2'd1, 1'b1, 12'h000, 10'd527,  10'd2},
    {2'd2, 1'b0, 12'h3C3, 10'd1023, 10'd5},
    {2'd2, 1'b1, 12'hFFF, 10'd0,    10'd0},
    {2'd0, 1'b1, 12'h800, 10'd0,    10'd0},
    {2'd1, 1'b0, 12'h123, 10'd5,    10'd0}
  };

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(cs_n_o === 1'b1 && sck_o === 1'b0 && busy_o === 1'b0, "R1", "reset outputs",
          64'({cs_n_o, sck_o, busy_o}), 64'b100);
    check(done_o === 1'b0 && err_o === 1'b0 && rd_valid_o === 1'b0 && wr_take_o === 1'b0,
          "R1", "reset strobes", 64'({done_o, err_o, rd_valid_o, wr_take_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < 8; i++)
      run_txn(int'(VEC[i][34:33]), int'(VEC[i][32]), int'(VEC[i][31:20]),
              int'(VEC[i][19:10]), int'(VEC[i][9:0]), 1'b0);

    // R11
    run_txn(0, 0, 12'h456, 10'd100, 2, 1'b1);

    // R9: out-of-range byte address, then reserved op
    begin
      int e0, d0, n0;
      bit cs_seen;
      e0 = err_cnt; d0 = done_cnt; n0 = nb_total; cs_seen = 1'b0;
      pulse_start(0, 0, 1, 528, 2);
      for (int c = 0; c < 10; c++) begin
        @(negedge clk_i);
        if (!cs_n_o || busy_o) cs_seen = 1'b1;
      end
      pulse_start(3, 0, 1, 3, 1);
      for (int c = 0; c < 10; c++) begin
        @(negedge clk_i);
        if (!cs_n_o || busy_o) cs_seen = 1'b1;
      end
      check(err_cnt - e0 == 2, "R9", "err pulses", 64'(err_cnt - e0), 64'd2);
      check(!cs_seen && done_cnt == d0 && nb_total == n0, "R9", "no transaction",
            64'(nb_total - n0), 64'd0);
    end

    // R10/R5: select gap and clock idle after completion
    begin
      int d0, hi;
      d0 = done_cnt;
      pulse_start(2, 0, 12'h010, 0, 0);
      while (cs_n_o) @(negedge clk_i);
      while (!cs_n_o) @(negedge clk_i);
      hi = 0;
      while (done_cnt == d0 && hi < 20) begin
        if (cs_n_o) hi++;
        @(negedge clk_i);
      end
      check(hi >= 2 && !sck_o, "R10", "cs high cycles before done", 64'(hi), 64'd2);
      check(!busy_o && !sck_o, "R5", "idle after done", 64'({busy_o, sck_o}), 64'd0);
    end

    report();
  end
endmodule